// File: doc/BRIEF.md
# Serial Shift Unit with Selectable Clock Sources

This block is a general-purpose serial shifter for a processor subsystem. It holds an 8-bit shift register, a latch that drives the serial output, and a 4-bit transfer counter. Software sets up and observes the unit through a small register port. A two-bit mode field and one select bit decide what advances the shift register and, separately, what advances the counter. The choices are nothing, a software strobe, a timer overflow pulse, or an edge of an external serial clock pin.

When the external clock drives the unit, the output latch updates on the edge opposite the sampling edge. This keeps the serial output stable around each sampling point. With the strobe or timer sources, the latch is transparent. A toggle bit lets a master generate its own clock pin. In external mode the same toggle writes can advance the counter, so a master learns early that a transfer has finished.

The clock pin and the data input pass through two-flop synchronizers, and everything runs on the system clock. Register map (defaults): address 0 is the shift register (read/write); address 1 holds the counter in bits [3:0] and the sticky wrap flag in bit 4; address 2 is control: bits [1:0] mode, bit 2 strobe/counter-select, bit 3 toggle, bit 4 clock pin direction. Address 3 reads zero.

Top module: `sshift_unit`

## Requirements
- R1: After synchronous reset, the shift register, counter, wrap flag, mode, select bit, direction, clock pin output, serial output and read data are all 0.
- R2: In mode 00, timer pulses and clock pin edges change neither register nor counter. A control write with bits [1:0]=00 and bit 2=1 shifts the register one place toward the MSB, putting the synchronized serial input into bit 0, and adds one to the counter. The synchronized serial input is the pin value two clock edges earlier.
- R3: Control bits 2 and 3 always read back as 0.
- R4: In mode 01, each cycle with the timer overflow input high shifts the register and increments the counter, whatever the select bit is.
- R5: In mode 10 with select bit 0, a synchronized rising edge of the clock pin shifts the register, and both edges increment the counter.
- R6: In mode 11, the register shifts on a synchronized falling edge and not on a rising edge.
- R7: In modes 10/11 with select bit 1, clock pin edges do not count. Instead, each control write with bit 1, bit 2 and bit 3 all set increments the counter.
- R8: A control write with bit 3 set inverts the clock pin output, whatever the direction bit is. Control bit 4 drives the clock pin output enable.
- R9: In modes 00 and 01, the serial output equals the register MSB from the same clock edge that changes the register.
- R10: In modes 10 and 11, the serial output changes only on the edge opposite the shifting edge. There it takes the current MSB, and data writes do not reach it directly.
- R11: When the counter increments from 15, it wraps to 0 and sets the sticky wrap flag. Writing address 1 with bit 4 set clears the flag; writing bit 4 as 0 leaves it.
- R12: Writes to addresses 0 and 1 preload the register and the counter. Read data shows the addressed register one clock after the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Register write enable |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| ser_in | input | 1 | Serial data input |
| ser_out | output | 1 | Serial data output from the output latch |
| sclk_in | input | 1 | External serial clock pin input |
| sclk_out | output | 1 | Serial clock pin output value |
| sclk_oe | output | 1 | Serial clock pin output enable |
| tmr_ovf | input | 1 | Timer overflow pulse |

## Verification
Several properties are checked on every cycle:
- In the strobe and timer modes, the serial output follows the MSB.
- In external mode, the output latch holds between opposite-edge events.
- The counter does not move without a tick or a preload.
- The wrap flag is set on wrap and stays set until cleared.
- Every toggle flips the clock pin.
- The strobe and toggle bits read as zero.

Which source advances which part in each mode needs the bench's scenarios: the register contents after sequences of strobes, timer pulses and pin edges. So do the counter values under edge counting versus toggle counting, and the exact edge on which the external-mode output latch changes.

// File: rtl/sshift_pkg.sv
package sshift_pkg;
  typedef enum logic [1:0] {
    CS_NONE     = 2'b00,
    CS_TIMER    = 2'b01,
    CS_EXT_RISE = 2'b10,
    CS_EXT_FALL = 2'b11
  } csel_e;

  localparam logic [1:0] A_DATA = 2'd0;
  localparam logic [1:0] A_CNT  = 2'd1;
  localparam logic [1:0] A_CTRL = 2'd2;

  localparam int unsigned CB_STROBE = 2;
  localparam int unsigned CB_TOGGLE = 3;
  localparam int unsigned CB_DIR    = 4;
endpackage

// File: rtl/sshift_sync.sv
module sshift_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/sshift_clksel.sv
module sshift_clksel
  import sshift_pkg::*;
(
  input  csel_e      csel,
  input  logic       cnt_src,
  input  logic       wr_ctrl,
  input  logic [3:0] ctrl_wbits,
  input  logic       tmr_ovf,
  input  logic       pin_rise,
  input  logic       pin_fall,
  output logic       shift_tick,
  output logic       cnt_tick,
  output logic       latch_tick,
  output logic       transparent
);
  logic sw_strobe;
  logic tgl_count;
  logic mode_shift;
  logic mode_cnt;

  // Strobes are decoded from the value being written.
  assign sw_strobe = wr_ctrl && (ctrl_wbits[1:0] == CS_NONE) && ctrl_wbits[CB_STROBE];
  assign tgl_count = wr_ctrl && ctrl_wbits[1] && ctrl_wbits[CB_STROBE] && ctrl_wbits[CB_TOGGLE];

  always_comb begin
    mode_shift = 1'b0;
    mode_cnt   = 1'b0;
    latch_tick = 1'b0;
    unique case (csel)
      CS_NONE: begin
      end
      CS_TIMER: begin
        mode_shift = tmr_ovf;
        mode_cnt   = tmr_ovf;
      end
      CS_EXT_RISE: begin
        mode_shift = pin_rise;
        latch_tick = pin_fall;
        mode_cnt   = !cnt_src && (pin_rise || pin_fall);
      end
      CS_EXT_FALL: begin
        mode_shift = pin_fall;
        latch_tick = pin_rise;
        mode_cnt   = !cnt_src && (pin_rise || pin_fall);
      end
      default: begin
      end
    endcase
  end

  assign shift_tick  = sw_strobe || mode_shift;
  assign cnt_tick    = sw_strobe || tgl_count || mode_cnt;
  assign transparent = wr_ctrl ? !ctrl_wbits[1] : !csel[1];
endmodule

// File: rtl/sshift_shreg.sv
module sshift_shreg #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  input  logic              shift,
  input  logic              bit_in,
  input  logic              latch_tick,
  input  logic              transparent,
  output logic [DATA_W-1:0] sreg,
  output logic              dout
);
  logic [DATA_W-1:0] sreg_n;

  always_comb begin
    if (load)       sreg_n = load_val;
    else if (shift) sreg_n = {sreg[DATA_W-2:0], bit_in};
    else            sreg_n = sreg;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg <= '0;
      dout <= 1'b0;
    end else begin
      sreg <= sreg_n;
      if (transparent)     dout <= sreg_n[DATA_W-1];
      else if (latch_tick) dout <= sreg[DATA_W-1];
    end
  end
endmodule

// File: rtl/sshift_counter.sv
module sshift_counter #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap_flag
);
  logic at_top;
  assign at_top = (cnt == {CNT_W{1'b1}});

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      wrap_flag <= 1'b0;
    end else begin
      if (load)      cnt <= load_val;
      else if (tick) cnt <= cnt + CNT_W'(1);
      if (tick && !load && at_top) wrap_flag <= 1'b1;
      else if (flag_clr)           wrap_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/sshift_unit.sv
module sshift_unit
  import sshift_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 4,
  parameter int unsigned SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              ser_in,
  output logic              ser_out,
  input  logic              sclk_in,
  output logic              sclk_out,
  output logic              sclk_oe,
  input  logic              tmr_ovf
);
  localparam int unsigned FLAG_BIT = CNT_W;
  localparam int unsigned STAT_PAD = DATA_W - CNT_W - 1;
  localparam int unsigned CTRL_PAD = DATA_W - CB_DIR - 1;

  logic  wr_data, wr_cnt, wr_ctrl, tgl_wr;
  csel_e csel_q;
  logic  cnt_src_q, dir_q, sclk_q;
  logic  pin_s, pin_d, din_s, pin_rise, pin_fall;
  logic  shift_tick, cnt_tick, latch_tick, transparent;
  logic  flag_clr;
  logic [DATA_W-1:0] sreg;
  logic [CNT_W-1:0]  cnt;
  logic              wrap_flag;
  logic [DATA_W-1:0] rd_mux;

  assign wr_data  = reg_wr && (reg_addr == A_DATA);
  assign wr_cnt   = reg_wr && (reg_addr == A_CNT);
  assign wr_ctrl  = reg_wr && (reg_addr == A_CTRL);
  assign tgl_wr   = wr_ctrl && reg_wdata[CB_TOGGLE];
  assign flag_clr = wr_cnt && reg_wdata[FLAG_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      csel_q    <= CS_NONE;
      cnt_src_q <= 1'b0;
      dir_q     <= 1'b0;
      sclk_q    <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        csel_q    <= csel_e'(reg_wdata[1:0]);
        cnt_src_q <= reg_wdata[CB_STROBE];
        dir_q     <= reg_wdata[CB_DIR];
      end
      if (tgl_wr) sclk_q <= !sclk_q;
    end
  end

  sshift_sync #(.STAGES(SYNC_N)) u_sync_pin (
    .clk(clk), .rst(rst), .d(sclk_in), .q(pin_s)
  );
  sshift_sync #(.STAGES(SYNC_N)) u_sync_din (
    .clk(clk), .rst(rst), .d(ser_in), .q(din_s)
  );

  always_ff @(posedge clk) begin
    if (rst) pin_d <= 1'b0;
    else     pin_d <= pin_s;
  end
  assign pin_rise = pin_s && !pin_d;
  assign pin_fall = !pin_s && pin_d;

  sshift_clksel u_clksel (
    .csel        (csel_q),
    .cnt_src     (cnt_src_q),
    .wr_ctrl     (wr_ctrl),
    .ctrl_wbits  (reg_wdata[3:0]),
    .tmr_ovf     (tmr_ovf),
    .pin_rise    (pin_rise),
    .pin_fall    (pin_fall),
    .shift_tick  (shift_tick),
    .cnt_tick    (cnt_tick),
    .latch_tick  (latch_tick),
    .transparent (transparent)
  );

  sshift_shreg #(.DATA_W(DATA_W)) u_shreg (
    .clk         (clk),
    .rst         (rst),
    .load        (wr_data),
    .load_val    (reg_wdata),
    .shift       (shift_tick),
    .bit_in      (din_s),
    .latch_tick  (latch_tick),
    .transparent (transparent),
    .sreg        (sreg),
    .dout        (ser_out)
  );

  sshift_counter #(.CNT_W(CNT_W)) u_counter (
    .clk       (clk),
    .rst       (rst),
    .load      (wr_cnt),
    .load_val  (reg_wdata[CNT_W-1:0]),
    .tick      (cnt_tick),
    .flag_clr  (flag_clr),
    .cnt       (cnt),
    .wrap_flag (wrap_flag)
  );

  always_comb begin
    unique case (reg_addr)
      A_DATA:  rd_mux = sreg;
      A_CNT:   rd_mux = {{STAT_PAD{1'b0}}, wrap_flag, cnt};
      A_CTRL:  rd_mux = {{CTRL_PAD{1'b0}}, dir_q, 2'b00, csel_q};
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_mux;
  end

  assign sclk_out = sclk_q;
  assign sclk_oe  = dir_q;
endmodule

// File: rtl/sshift_unit_chk.sv
module sshift_unit_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        reg_addr,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              wr_ctrl,
  input logic              tgl_wr,
  input logic [1:0]        csel,
  input logic              msb,
  input logic              dout,
  input logic              latch_tick,
  input logic              cnt_tick,
  input logic              cnt_load,
  input logic [CNT_W-1:0]  cnt,
  input logic              wrap_flag,
  input logic              flag_clr,
  input logic              sclk_out
);
  assert_rd_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == 2'd2) |=> (reg_rdata[3:2] == 2'b00));

  assert_transparent_R9: assert property (@(posedge clk) disable iff (rst)
    (!csel[1] && !wr_ctrl) |=> (dout == msb));

  assert_latch_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (csel[1] && !wr_ctrl && !latch_tick) |=> $stable(dout));

  assert_cnt_idle_R2: assert property (@(posedge clk) disable iff (rst)
    (!cnt_tick && !cnt_load) |=> $stable(cnt));

  assert_wrap_set_R11: assert property (@(posedge clk) disable iff (rst)
    (cnt_tick && !cnt_load && (cnt == {CNT_W{1'b1}})) |=> (wrap_flag && (cnt == '0)));

  assert_flag_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    (wrap_flag && !flag_clr) |=> wrap_flag);

  assert_toggle_R8: assert property (@(posedge clk) disable iff (rst)
    tgl_wr |=> (sclk_out != $past(sclk_out)));

  assert_toggle_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !tgl_wr |=> $stable(sclk_out));
endmodule

bind sshift_unit sshift_unit_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .reg_addr   (reg_addr),
  .reg_rdata  (reg_rdata),
  .wr_ctrl    (wr_ctrl),
  .tgl_wr     (tgl_wr),
  .csel       (csel_q),
  .msb        (sreg[DATA_W-1]),
  .dout       (ser_out),
  .latch_tick (latch_tick),
  .cnt_tick   (cnt_tick),
  .cnt_load   (wr_cnt),
  .cnt        (cnt),
  .wrap_flag  (wrap_flag),
  .flag_clr   (flag_clr),
  .sclk_out   (sclk_out)
);

// File: tb/sshift_unit_tb.sv
module sshift_unit_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] reg_addr = 2'd0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       ser_in = 1'b0;
  logic       ser_out;
  logic       sclk_in = 1'b0;
  logic       sclk_out;
  logic       sclk_oe;
  logic       tmr_ovf = 1'b0;

  int  n_checks = 0;
  int  n_err = 0;
  bit  done = 1'b0;

  always #5 clk = ~clk;

  sshift_unit u_dut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ser_in(ser_in),
    .ser_out(ser_out), .sclk_in(sclk_in), .sclk_out(sclk_out),
    .sclk_oe(sclk_oe), .tmr_ovf(tmr_ovf)
  );

  // {preload[7:0], serial in, expected register[7:0], expected serial out}
  localparam logic [17:0] VECS [6] = '{
    {8'hA5, 1'b1, 8'h4B, 1'b0},
    {8'hA5, 1'b0, 8'h4A, 1'b0},
    {8'h80, 1'b0, 8'h00, 1'b0},
    {8'h7F, 1'b1, 8'hFF, 1'b1},
    {8'hC0, 1'b0, 8'h80, 1'b1},
    {8'h01, 1'b1, 8'h03, 1'b0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic pin(input logic v);
    @(negedge clk);
    sclk_in = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic tmr_pulse();
    @(negedge clk);
    tmr_ovf = 1'b1;
    @(negedge clk);
    tmr_ovf = 1'b0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] rv;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 ser_out", ser_out, 0);
    check("R1 sclk_out", sclk_out, 0);
    check("R1 sclk_oe", sclk_oe, 0);
    check("R1 rdata", reg_rdata, 0);
    rd(2'd0, rv); check("R1 data", rv, 8'h00);
    rd(2'd1, rv); check("R1 count", rv, 8'h00);
    rd(2'd2, rv); check("R1 ctrl", rv, 8'h00);

    // R2/R9 software strobe vector table
    wr(2'd1, 8'h00);
    for (int i = 0; i < 6; i++) begin
      wr(2'd0, VECS[i][17:10]);
      check("R9 load follows msb", ser_out, VECS[i][17]);
      ser_in = VECS[i][9];
      repeat (3) @(negedge clk);
      wr(2'd2, 8'h04);
      check("R9 strobe output", ser_out, VECS[i][0]);
      rd(2'd0, rv); check("R2 strobe shift", rv, VECS[i][8:1]);
      rd(2'd1, rv); check("R2 strobe count", rv, i + 1);
    end

    // R3 strobe/toggle read zero, R8 toggle and direction
    rd(2'd2, rv); check("R3 strobe reads 0", rv, 8'h00);
    wr(2'd2, 8'h18);
    check("R8 toggle high", sclk_out, 1);
    check("R8 oe set", sclk_oe, 1);
    rd(2'd2, rv); check("R3 toggle reads 0", rv, 8'h10);
    wr(2'd2, 8'h08);
    check("R8 toggle with oe off", sclk_out, 0);
    check("R8 oe clear", sclk_oe, 0);

    // R2 no clock in mode 00
    tmr_pulse();
    pin(1'b1);
    pin(1'b0);
    rd(2'd0, rv); check("R2 idle data", rv, 8'h03);
    rd(2'd1, rv); check("R2 idle count", rv, 8'h06);

    // R4 timer mode
    ser_in = 1'b1;
    wr(2'd2, 8'h01);
    wr(2'd0, 8'h81);
    check("R9 timer load msb", ser_out, 1);
    tmr_pulse();
    check("R9 timer output", ser_out, 0);
    rd(2'd0, rv); check("R4 timer shift", rv, 8'h03);
    rd(2'd1, rv); check("R4 timer count", rv, 8'h07);
    wr(2'd2, 8'h05);
    rd(2'd0, rv); check("R4 strobe bit ignored", rv, 8'h03);
    tmr_pulse();
    rd(2'd0, rv); check("R4 second shift", rv, 8'h07);
    rd(2'd1, rv); check("R4 second count", rv, 8'h08);

    // R5 external rising edge, R10 output on falling edge
    ser_in = 1'b0;
    wr(2'd2, 8'h02);
    wr(2'd1, 8'h00);
    wr(2'd0, 8'hC1);
    check("R10 load not passed", ser_out, 0);
    pin(1'b1);
    rd(2'd0, rv); check("R5 rise shift", rv, 8'h82);
    rd(2'd1, rv); check("R5 rise count", rv, 8'h01);
    check("R10 hold on rise", ser_out, 0);
    pin(1'b0);
    rd(2'd0, rv); check("R5 fall no shift", rv, 8'h82);
    rd(2'd1, rv); check("R5 fall count", rv, 8'h02);
    check("R10 latch on fall", ser_out, 1);

    // R6 external falling edge
    wr(2'd2, 8'h03);
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h40);
    ser_in = 1'b1;
    pin(1'b1);
    rd(2'd0, rv); check("R6 rise no shift", rv, 8'h40);
    check("R10 latch on rise", ser_out, 0);
    pin(1'b0);
    rd(2'd0, rv); check("R6 fall shift", rv, 8'h81);
    check("R10 hold on fall", ser_out, 0);
    pin(1'b1);
    check("R10 latch new msb", ser_out, 1);
    rd(2'd1, rv); check("R6 count both edges", rv, 8'h03);

    // R7 counter by toggle in external mode
    wr(2'd2, 8'h06);
    wr(2'd1, 8'h00);
    pin(1'b0);
    pin(1'b1);
    rd(2'd0, rv); check("R7 shift still on edge", rv, 8'h03);
    rd(2'd1, rv); check("R7 edges not counted", rv, 8'h00);
    wr(2'd2, 8'h0E);
    check("R8 toggle in ext", sclk_out, 1);
    rd(2'd1, rv); check("R7 toggle count 1", rv, 8'h01);
    wr(2'd2, 8'h0E);
    rd(2'd1, rv); check("R7 toggle count 2", rv, 8'h02);
    wr(2'd2, 8'h0A);
    rd(2'd1, rv); check("R7 toggle w/o select", rv, 8'h02);

    // R11 wrap and sticky flag, R12 preload
    wr(2'd2, 8'h00);
    wr(2'd1, 8'h0E);
    rd(2'd1, rv); check("R12 count preload", rv, 8'h0E);
    wr(2'd2, 8'h04);
    wr(2'd2, 8'h04);
    rd(2'd1, rv); check("R11 wrap sets flag", rv, 8'h10);
    wr(2'd1, 8'h05);
    rd(2'd1, rv); check("R11 flag kept", rv, 8'h15);
    wr(2'd1, 8'h10);
    rd(2'd1, rv); check("R11 flag cleared", rv, 8'h00);
    wr(2'd0, 8'h5A);
    rd(2'd0, rv); check("R12 data preload", rv, 8'h5A);

    // R1 reset during operation
    sclk_in = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1 reset ser_out", ser_out, 0);
    check("R1 reset sclk_out", sclk_out, 0);
    rst = 1'b0;
    rd(2'd0, rv); check("R1 reset data", rv, 8'h00);
    rd(2'd1, rv); check("R1 reset count", rv, 8'h00);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule